// File: doc/BRIEF.md
# Dual-Format Frame-Sync PCM Time-Slot Port

This block is one channel of an 8-bit serial PCM port. All traffic is timed by a shared bit clock. A transmit sync input opens a slot in which one byte goes out, most significant bit first, on a serial output that can be put in high impedance. A receive sync input opens a slot in which one byte is captured from a serial input. The bit clock, the two syncs and the serial input are assumed to be already synchronous to the core clock `clk`. The block detects bit-clock edges by comparing each sample with the previous one. Every output is registered, so it changes on the first `clk` edge that samples the new bit-clock level. The one exception is the output enable, which the power-down input also gates directly.

A static format input selects the framing for the whole port. In short-sync framing, the sync must be high for one bit and is taken on a bit-clock falling edge. In long-sync framing, a rising edge of the sync starts the frame, and the sync should stay high for at least three bit periods. In long-sync framing, a sync that is too short raises a one-cycle error flag. Internal logic supplies the transmit byte. It sees a one-cycle pulse when that byte is taken, and a one-cycle valid strobe with each received byte. A power-down input keeps the output in high impedance and discards receive data.

Top module: `pcm_slot_port`

## Requirements
- R1: Short-sync transmit (`long_fmt`=0). If `fsx` is high when a bit-clock falling edge is sampled, `dx_oe` rises at the next bit-clock rising edge. It is visible one `clk` after the edge that samples `bclk` high, and `dx_data` then carries bit 7 of the byte.
- R2: After the enabling edge, each of the next 7 bit-clock rising edges moves to the next lower bit, so the bits go out 7 down to 0. The 8th rising edge after the enabling edge returns `dx_oe` to 0. `tx_take` pulses for one `clk` when `tx_byte` is sampled, which is at the enabling edge.
- R3: Long-sync transmit (`long_fmt`=1). A rising edge of `fsx` arms the slot. The output is enabled at the later of that sync edge and a bit-clock rising edge. If `bclk` is already high, the enable follows two `clk` cycles after the sync rise.
- R4: Short-sync receive. If `fsr` is high when a bit-clock falling edge is sampled, the next 8 falling edges capture `dr` as bits 7 down to 0.
- R5: Long-sync receive. After a rising edge of `fsr`, the next 8 bit-clock falling edges capture `dr` as bits 7 down to 0.
- R6: `rx_valid` is high for exactly one `clk`, in the cycle after the 8th capture. `rx_byte` then shows the byte and holds it until the next strobe.
- R7: While `pdn` is 1, `dx_oe` is 0 and no frame starts. Raising `pdn` during a slot ends that slot, and the slot does not resume when `pdn` falls. A receive slot ended this way gives no `rx_valid`.
- R8: A sync pulse that arrives while a transmit or receive byte is in progress is ignored. That byte completes unchanged, and no second byte follows.
- R9: In long-sync framing, `tx_sync_err` or `rx_sync_err` pulses for one `clk` when its sync falls after fewer than 3 bit-clock falling edges were seen since the sync rose. A framing error does not stop the byte.
- R10: In short-sync framing, neither sync error flag is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk | input | 1 | Bit clock, sampled by `clk` |
| long_fmt | input | 1 | Framing select: 0 short-sync, 1 long-sync (static) |
| pdn | input | 1 | Power-down |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| tx_byte | input | 8 | Byte to transmit in the next transmit slot |
| dr | input | 1 | Serial receive data |
| tx_take | output | 1 | One-cycle pulse: `tx_byte` was sampled |
| dx_data | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Output enable for the serial data pin (0 = high impedance) |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: new `rx_byte` |
| tx_sync_err | output | 1 | Short long-sync pulse on `fsx` |
| rx_sync_err | output | 1 | Short long-sync pulse on `fsr` |

## Verification
The bench builds the port with its default parameters: an 8-bit slot and a minimum long-sync width of 3 bit periods. It drives the bit clock at one eighth of `clk`. With that ratio, syncs can be placed in the high or the low half of a bit period, so both branches of the long-sync "later edge" rule are reached. Framing-error cases take a single bit period, which is enough to fall below the 3-edge minimum. The syncs are pulsed a second time mid-byte, and power-down is raised both before a slot and partway through one.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_ARMED = 2'd1,
        SLOT_SHIFT = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    localparam int SIG_BCLK  = 0;
    localparam int SIG_FSX   = 1;
    localparam int SIG_FSR   = 2;
    localparam int SIG_COUNT = 3;

    // Frame opening rule for both directions: long-sync opens on the sync's
    // rising edge, short-sync on a bit-clock fall that sees the sync high.
    function automatic logic frame_open(input logic long_fmt,
                                        input edge_t bclk_ev,
                                        input edge_t sync_ev);
        return long_fmt ? sync_ev.rise : (bclk_ev.fall & sync_ev.level);
    endfunction

endpackage

// File: rtl/pcm_edge_track.sv
module pcm_edge_track
    import pcm_slot_pkg::*;
#(
    parameter int N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     sig,
    output edge_t [N-1:0]    ev
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign ev[i].level = sig[i];
        assign ev[i].rise  = sig[i] & ~prev_q[i];
        assign ev[i].fall  = ~sig[i] & prev_q[i];
    end

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_slot_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              long_fmt,
    input  logic              pdn,
    input  edge_t             bclk_ev,
    input  edge_t             fsx_ev,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_take,
    output logic              dx_data,
    output logic              dx_oe
);

    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    slot_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SLOT_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx_take <= 1'b0;
        end else begin
            tx_take <= 1'b0;
            unique case (state)
                SLOT_IDLE: begin
                    if (!pdn && frame_open(long_fmt, bclk_ev, fsx_ev))
                        state <= SLOT_ARMED;
                end
                SLOT_ARMED: begin
                    // Enable at the first cycle that sees the bit clock high:
                    // covers both "sync later" and "clock later" cases.
                    if (pdn) begin
                        state <= SLOT_IDLE;
                    end else if (bclk_ev.level) begin
                        state   <= SLOT_SHIFT;
                        sh      <= tx_byte;
                        cnt     <= '0;
                        tx_take <= 1'b1;
                    end
                end
                SLOT_SHIFT: begin
                    if (pdn) begin
                        state <= SLOT_IDLE;
                    end else if (bclk_ev.rise) begin
                        if (cnt == LAST) begin
                            state <= SLOT_IDLE;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    assign dx_oe   = (state == SLOT_SHIFT) && !pdn;
    assign dx_data = dx_oe & sh[BYTE_W-1];

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_SHIFT && !bclk_ev.rise && !pdn) |=> $stable(sh));

    // R2
    take_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> !tx_take);

    // R7
    pdn_ends_slot_chk: assert property (@(posedge clk) disable iff (rst)
        pdn |=> (state == SLOT_IDLE));

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_slot_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              long_fmt,
    input  logic              pdn,
    input  edge_t             bclk_ev,
    input  edge_t             fsr_ev,
    input  logic              dr,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    slot_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_next;

    assign sh_next = {sh[BYTE_W-2:0], dr};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SLOT_IDLE;
            cnt      <= '0;
            sh       <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                SLOT_IDLE: begin
                    if (!pdn && frame_open(long_fmt, bclk_ev, fsr_ev)) begin
                        state <= SLOT_SHIFT;
                        cnt   <= '0;
                    end
                end
                SLOT_SHIFT: begin
                    if (pdn) begin
                        state <= SLOT_IDLE;
                    end else if (bclk_ev.fall) begin
                        sh <= sh_next;
                        if (cnt == LAST) begin
                            state    <= SLOT_IDLE;
                            rx_byte  <= sh_next;
                            rx_valid <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_byte));

    // R7
    valid_powered_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !$past(pdn));

endmodule

// File: rtl/pcm_sync_width.sv
module pcm_sync_width
    import pcm_slot_pkg::*;
#(
    parameter int MIN_BITS = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  long_fmt,
    input  edge_t bclk_ev,
    input  edge_t sync_ev,
    output logic  err
);

    localparam int W = $clog2(MIN_BITS + 1);
    localparam logic [W-1:0] MINV = W'(MIN_BITS);

    logic         meas;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            meas <= 1'b0;
            cnt  <= '0;
            err  <= 1'b0;
        end else begin
            err <= 1'b0;
            if (!long_fmt) begin
                meas <= 1'b0;
            end else if (sync_ev.rise) begin
                meas <= 1'b1;
                cnt  <= '0;
            end else if (meas) begin
                if (!sync_ev.level) begin
                    meas <= 1'b0;
                    err  <= (cnt < MINV);
                end else if (bclk_ev.fall && (cnt < MINV)) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10
    err_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(long_fmt));

    // R9
    err_at_sync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !$past(sync_ev.level));

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int MIN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              long_fmt,
    input  logic              pdn,
    input  logic              fsx,
    input  logic              fsr,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              dr,
    output logic              tx_take,
    output logic              dx_data,
    output logic              dx_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_sync_err,
    output logic              rx_sync_err
);

    logic  [SIG_COUNT-1:0] raw;
    edge_t [SIG_COUNT-1:0] ev;

    assign raw[SIG_BCLK] = bclk;
    assign raw[SIG_FSX]  = fsx;
    assign raw[SIG_FSR]  = fsr;

    pcm_edge_track #(.N(SIG_COUNT)) u_edges (
        .clk (clk),
        .rst (rst),
        .sig (raw),
        .ev  (ev)
    );

    pcm_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .long_fmt (long_fmt),
        .pdn      (pdn),
        .bclk_ev  (ev[SIG_BCLK]),
        .fsx_ev   (ev[SIG_FSX]),
        .tx_byte  (tx_byte),
        .tx_take  (tx_take),
        .dx_data  (dx_data),
        .dx_oe    (dx_oe)
    );

    pcm_rx_slot #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .long_fmt (long_fmt),
        .pdn      (pdn),
        .bclk_ev  (ev[SIG_BCLK]),
        .fsr_ev   (ev[SIG_FSR]),
        .dr       (dr),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    pcm_sync_width #(.MIN_BITS(MIN_BITS)) u_wx (
        .clk      (clk),
        .rst      (rst),
        .long_fmt (long_fmt),
        .bclk_ev  (ev[SIG_BCLK]),
        .sync_ev  (ev[SIG_FSX]),
        .err      (tx_sync_err)
    );

    pcm_sync_width #(.MIN_BITS(MIN_BITS)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .long_fmt (long_fmt),
        .bclk_ev  (ev[SIG_BCLK]),
        .sync_ev  (ev[SIG_FSR]),
        .err      (rx_sync_err)
    );

    // R1
    oe_on_high_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dx_oe) |-> $past(bclk));

endmodule

// File: tb/pcm_slot_port_tb_top.sv
module pcm_slot_port_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       bclk = 1'b1, long_fmt = 1'b0, pdn = 1'b0;
    logic       fsx = 1'b0, fsr = 1'b0, dr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_take, dx_data, dx_oe, rx_valid, tx_sync_err, rx_sync_err;
    logic [7:0] rx_byte;

    pcm_slot_port dut_i (
        .clk(clk), .rst(rst), .bclk(bclk), .long_fmt(long_fmt), .pdn(pdn),
        .fsx(fsx), .fsr(fsr), .tx_byte(tx_byte), .dr(dr),
        .tx_take(tx_take), .dx_data(dx_data), .dx_oe(dx_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_sync_err(tx_sync_err), .rx_sync_err(rx_sync_err)
    );

    int errors = 0;
    int checks = 0;
    int ph = 0;
    bit done = 0;
    bit dr_q[$];
    bit mon_q[$];
    int take_n = 0, valid_n = 0, txerr_n = 0, rxerr_n = 0;
    logic [7:0] last_rx = 8'h00;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // one core clock; bit clock = 8 core clocks, high in phases 0..3
    task automatic tick();
        @(posedge clk);
        #2;
        ph = (ph + 1) % 8;
        bclk = (ph < 4);
        if (ph == 0 && dr_q.size() > 0) dr = dr_q.pop_front();
    endtask

    task automatic to_ph(input int p);
        while (ph != p) tick();
    endtask

    task automatic clear_mon();
        mon_q.delete();
        take_n = 0; valid_n = 0; txerr_n = 0; rxerr_n = 0;
    endtask

    task automatic load_dr(input logic [7:0] b, input bit now);
        dr_q.delete();
        if (now) begin
            dr = b[7];
            for (int i = 6; i >= 0; i--) dr_q.push_back(b[i]);
        end else begin
            for (int i = 7; i >= 0; i--) dr_q.push_back(b[i]);
        end
    endtask

    task automatic check_bits(input string tag, input logic [7:0] b);
        logic [7:0] got;
        got = 8'h00;
        for (int i = 0; i < mon_q.size() && i < 8; i++) got = {got[6:0], mon_q[i]};
        check({tag, " bit count"}, mon_q.size(), 8);
        check({tag, " bits"}, got, b);
    endtask

    // event monitor, mid-clock
    always @(negedge clk) begin
        if (!rst) begin
            if (ph == 4 && dx_oe) mon_q.push_back(dx_data);
            if (tx_take) take_n++;
            if (rx_valid) begin valid_n++; last_rx = rx_byte; end
            if (tx_sync_err) txerr_n++;
            if (rx_sync_err) rxerr_n++;
        end
    end

    // behavioural reference model
    int   m_tx_st = 0, m_rx_st = 0;
    bit   m_txq[$];
    bit   m_rxq[$];
    bit   m_pb = 0, m_pfx = 0, m_pfr = 0;
    logic m_take = 0, m_valid = 0;
    logic [7:0] m_rxb = 8'h00;
    int   m_wc[2];
    bit   m_won[2];
    logic m_err[2];

    always @(posedge clk) begin
        bit rise_e, fall_e, fxr, frr, syn, syr;
        if (rst) begin
            m_tx_st = 0; m_rx_st = 0; m_txq.delete(); m_rxq.delete();
            m_pb = 0; m_pfx = 0; m_pfr = 0; m_take = 0; m_valid = 0; m_rxb = 8'h00;
            for (int k = 0; k < 2; k++) begin m_wc[k] = 0; m_won[k] = 0; m_err[k] = 0; end
        end else begin
            rise_e = bclk && !m_pb;
            fall_e = !bclk && m_pb;
            fxr = fsx && !m_pfx;
            frr = fsr && !m_pfr;
            m_take = 0; m_valid = 0; m_err[0] = 0; m_err[1] = 0;
            case (m_tx_st)
                0: if (!pdn && (long_fmt ? fxr : (fall_e && fsx))) m_tx_st = 1;
                1: if (pdn) m_tx_st = 0;
                   else if (bclk) begin
                       m_txq.delete();
                       for (int i = 7; i >= 0; i--) m_txq.push_back(tx_byte[i]);
                       m_take = 1; m_tx_st = 2;
                   end
                default: if (pdn) begin m_tx_st = 0; m_txq.delete(); end
                   else if (rise_e) begin
                       void'(m_txq.pop_front());
                       if (m_txq.size() == 0) m_tx_st = 0;
                   end
            endcase
            case (m_rx_st)
                0: if (!pdn && (long_fmt ? frr : (fall_e && fsr))) begin
                       m_rx_st = 1; m_rxq.delete();
                   end
                default: if (pdn) m_rx_st = 0;
                   else if (fall_e) begin
                       m_rxq.push_back(dr);
                       if (m_rxq.size() == 8) begin
                           for (int i = 0; i < 8; i++) m_rxb[7-i] = m_rxq[i];
                           m_valid = 1; m_rx_st = 0;
                       end
                   end
            endcase
            for (int k = 0; k < 2; k++) begin
                syn = (k == 0) ? fsx : fsr;
                syr = (k == 0) ? fxr : frr;
                if (!long_fmt) m_won[k] = 0;
                else if (syr) begin m_won[k] = 1; m_wc[k] = 0; end
                else if (m_won[k]) begin
                    if (!syn) begin m_won[k] = 0; m_err[k] = (m_wc[k] < 3); end
                    else if (fall_e && m_wc[k] < 3) m_wc[k]++;
                end
            end
            m_pb = bclk; m_pfx = fsx; m_pfr = fsr;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        logic exp_oe, exp_d;
        if (!rst && !done) begin
            exp_oe = (m_tx_st == 2) && !pdn;
            exp_d  = exp_oe ? m_txq[0] : 1'b0;
            check("R1 model dx_oe", dx_oe, exp_oe);
            check("R2 model dx_data", dx_data, exp_d);
            check("R2 model tx_take", tx_take, m_take);
            check("R6 model rx_valid", rx_valid, m_valid);
            check("R4 model rx_byte", rx_byte, m_rxb);
            check("R9 model tx_sync_err", tx_sync_err, m_err[0]);
            check("R9 model rx_sync_err", rx_sync_err, m_err[1]);
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        check("reset dx_oe", dx_oe, 0);
        check("reset rx_valid", rx_valid, 0);
        check("reset rx_byte", rx_byte, 0);

        // R1 / R2 short-sync transmit
        long_fmt = 0; clear_mon(); tx_byte = 8'hA5;
        to_ph(2); fsx = 1; repeat (3) tick(); fsx = 0;
        to_ph(0);
        check("R1 oe before rise", dx_oe, 0);
        tick();
        check("R1 oe after rise", dx_oe, 1);
        check("R1 sign bit", dx_data, 1);
        repeat (100) tick();
        check_bits("R2 short tx", 8'hA5);
        check("R2 take pulses", take_n, 1);
        check("R10 no tx err", txerr_n, 0);

        // R4 short-sync receive
        clear_mon();
        to_ph(2); fsr = 1; load_dr(8'h3C, 0); repeat (3) tick(); fsr = 0;
        repeat (100) tick();
        check("R6 one strobe", valid_n, 1);
        check("R4 short rx byte", last_rx, 8'h3C);
        check("R10 no rx err", rxerr_n, 0);

        // R3 long-sync, sync rises while bit clock low
        long_fmt = 1; clear_mon(); tx_byte = 8'h96;
        to_ph(5); fsx = 1;
        to_ph(0);
        check("R3 oe waits for clock", dx_oe, 0);
        tick();
        check("R3 oe at clock rise", dx_oe, 1);
        repeat (30) tick(); fsx = 0;
        repeat (100) tick();
        check_bits("R3 long tx low", 8'h96);
        check("R9 no err on wide sync", txerr_n, 0);

        // R3 long-sync, sync rises while bit clock high
        clear_mon(); tx_byte = 8'h3B;
        to_ph(1); fsx = 1;
        tick();
        check("R3 oe not yet", dx_oe, 0);
        tick();
        check("R3 oe at sync", dx_oe, 1);
        check("R3 sign bit", dx_data, 0);
        repeat (30) tick(); fsx = 0;
        repeat (100) tick();
        check_bits("R3 long tx high", 8'h3B);

        // R5 long-sync receive
        clear_mon();
        to_ph(1); fsr = 1; load_dr(8'h5A, 1);
        repeat (30) tick(); fsr = 0;
        repeat (100) tick();
        check("R5 one strobe", valid_n, 1);
        check("R5 long rx byte", last_rx, 8'h5A);
        check("R9 no rx err", rxerr_n, 0);

        // R9 too-short long syncs
        clear_mon(); tx_byte = 8'hC3;
        to_ph(1); fsx = 1; fsr = 1; load_dr(8'hE7, 1);
        repeat (8) tick(); fsx = 0; fsr = 0;
        repeat (100) tick();
        check("R9 tx err pulse", txerr_n, 1);
        check("R9 rx err pulse", rxerr_n, 1);
        check("R9 rx byte still done", last_rx, 8'hE7);
        check_bits("R9 tx still done", 8'hC3);

        // R8 sync mid-byte ignored (short-sync)
        long_fmt = 0; clear_mon(); tx_byte = 8'h81;
        to_ph(2); fsx = 1; fsr = 1; load_dr(8'h81, 0); repeat (3) tick(); fsx = 0; fsr = 0;
        repeat (24) tick();
        to_ph(2); fsx = 1; fsr = 1; repeat (3) tick(); fsx = 0; fsr = 0;
        tx_byte = 8'hFF;
        repeat (100) tick();
        check("R8 one take", take_n, 1);
        check_bits("R8 tx unchanged", 8'h81);
        check("R8 one strobe", valid_n, 1);
        check("R8 rx unchanged", last_rx, 8'h81);

        // R7 powered down across a frame
        clear_mon(); pdn = 1;
        to_ph(2); fsx = 1; fsr = 1; load_dr(8'h66, 0); repeat (3) tick(); fsx = 0; fsr = 0;
        repeat (100) tick();
        check("R7 no bits out", mon_q.size(), 0);
        check("R7 no take", take_n, 0);
        check("R7 no strobe", valid_n, 0);
        pdn = 0;

        // R7 power-down in mid-slot
        clear_mon(); tx_byte = 8'hFF;
        to_ph(2); fsx = 1; fsr = 1; load_dr(8'hFF, 0); repeat (3) tick(); fsx = 0; fsr = 0;
        repeat (20) tick();
        check("R7 oe before pdn", dx_oe, 1);
        pdn = 1; #1;
        check("R7 oe forced off", dx_oe, 0);
        repeat (10) tick(); pdn = 0;
        repeat (100) tick();
        check("R7 slot not resumed", dx_oe, 0);
        check("R7 partial byte", mon_q.size() < 8, 1);
        check("R7 aborted rx no strobe", valid_n, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule